// File: doc/BRIEF.md
# Interrupt Rate Throttling Timer

This block sits between a device's internal event logic and the single interrupt line to the host. It enforces a programmable minimum spacing between interrupt assertions, so the host is never interrupted more often than software allows, whatever the event rate. The spacing is set in a 32-bit read/write configuration word. Only its low 16 bits hold the interval, counted in units of 256 ns. An interval of zero turns throttling off.

A prescaler divides the system clock down to a 256 ns tick. The divide ratio is the parameter `TICK_DIV`, which is 32 for a 125 MHz clock and 64 for 250 MHz. Each interrupt assertion, called a fire, loads a hold-off counter with the current interval and restarts the prescaler. Events that arrive while the counter is running merge into one pending flag. When the window runs out, a pending flag causes exactly one new fire. If nothing is pending, the block goes idle, and the next event fires at once. The output stays high until the host clears it.

The controller has three named states. ST_IDLE means no window is running. ST_WAIT means a window is running and nothing is pending. ST_PEND means a window is running and at least one event is pending. The transitions are:
- IDLE_FIRE: ST_IDLE to ST_WAIT on an event with a non-zero interval.
- IDLE_BYPASS: ST_IDLE stays in ST_IDLE and fires on an event with a zero interval.
- WAIT_LATCH: ST_WAIT to ST_PEND on an event.
- WAIT_EXPIRE: ST_WAIT to ST_IDLE when the window ends and no event is present.
- WAIT_REFIRE: ST_WAIT fires when the window ends while an event is present.
- PEND_FIRE: ST_PEND fires when the window ends.

After any fire, the next state is ST_WAIT if the interval is non-zero, and ST_IDLE if it is zero.

Top module: `irt_throttle`

## Requirements
- R1: After reset, irq_out is 0 and cfg_rdata reads 0.
- R2: A write with cfg_we stores cfg_wdata[15:0] as the interval. The stored value appears on cfg_rdata[15:0] in the cycle after the write. cfg_rdata[31:16] always reads 0, whatever value was written to those bits.
- R3: With an interval of 0, an event sampled at a clock edge sets irq_out at that same edge, and no hold-off window is started.
- R4: After a fire with interval N > 0, no further fire can occur until N*TICK_DIV clock edges have passed (N*256 ns).
- R5: Any number of events during a window produce exactly one fire, at the edge N*TICK_DIV edges after the previous fire.
- R6: If nothing is pending when a window ends, the block goes idle. The next event then fires at its own edge and starts a new full window.
- R7: Once set, irq_out stays high until irq_clr is sampled. If a fire and irq_clr fall on the same edge, the fire wins and irq_out stays high.
- R8: A new interval written while a window is running does not change that window. It is used by the next fire that loads the counter.
- R9: While a window runs, the prescaler emits one tick every TICK_DIV cycles, counted from the fire that started the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data; the interval is in bits 15:0 |
| cfg_rdata | output | 32 | Configuration read data; bits 31:16 are always 0 |
| evt_in | input | 1 | Interrupt event request, level or single-cycle pulse |
| irq_clr | input | 1 | Host clear of the interrupt output |
| irq_out | output | 1 | Throttled interrupt to the host |

## Verification
Directed sequences cover several cases, each separating a different kind of fault:
- Bypass with a zero interval and an immediate refire.
- A single pending event measured edge by edge against N*TICK_DIV, which exposes off-by-one errors in the prescaler or counter.
- A long quiet gap followed by an event, which separates the idle refire from the pending refire.
- An interval rewrite in the middle of a window, which shows whether the running window is cut short or left alone.

A long run of random events, clears and interval writes, with an interval of 0 to 4, is checked every cycle against a timestamp model. This run catches faults in coalescing and in the order of clear and fire that the directed cases miss.

// File: rtl/irt_pkg.sv
package irt_pkg;

    // Width of the programmable interval field and of the register word.
    localparam int unsigned IVL_W = 16;
    localparam int unsigned REG_W = 32;

    // Controller states: no window, window without pending event,
    // window with at least one pending event.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_PEND = 2'd2
    } irt_state_e;

endpackage

// File: rtl/irt_prescaler.sv
module irt_prescaler #(
    parameter int unsigned DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);

    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    generate
        if (DIV > 1) begin : g_div
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (restart) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign tick = (cnt_q == LAST);

            // R9: two ticks are never back to back when the ratio exceeds one.
            a_r9_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick && !restart |=> !tick);

            // R9: a restart always yields a quiet cycle before the next tick.
            a_r9_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                restart |=> !tick);
        end else begin : g_pass
            assign tick = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/irt_holdoff.sv
module irt_holdoff #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         run,
    output logic         expire
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign run    = (cnt_q != '0);
    assign expire = tick && (cnt_q == W'(1));

    // R4: the counter is only reloaded when no window is live or it ends now.
    a_r4_no_early_reload: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!run || expire));

    // R8: a running window keeps its count when no tick and no load occur.
    a_r8_window_kept: assert property (@(posedge clk) disable iff (!rst_n)
        run && !load && !tick |=> cnt_q == $past(cnt_q));

endmodule

// File: rtl/irt_ctrl.sv
module irt_ctrl
    import irt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt,
    input  logic       clr,
    input  logic       ivl_zero,
    input  logic       expire,
    input  logic       run,
    output logic       fire,
    output logic       load,
    output logic       irq_out,
    output irt_state_e state
);

    irt_state_e state_q;
    irt_state_e state_d;

    // Next state and fire decision.
    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (evt) begin
                    fire    = 1'b1;
                    state_d = ivl_zero ? ST_IDLE : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (expire) begin
                    if (evt) begin
                        fire    = 1'b1;
                        state_d = ivl_zero ? ST_IDLE : ST_WAIT;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else if (evt) begin
                    state_d = ST_PEND;
                end
            end
            ST_PEND: begin
                if (expire) begin
                    fire    = 1'b1;
                    state_d = ivl_zero ? ST_IDLE : ST_WAIT;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign load = fire && !ivl_zero;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: a fire sets, a host clear drops, fire wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_out <= 1'b0;
        end else if (fire) begin
            irq_out <= 1'b1;
        end else if (clr) begin
            irq_out <= 1'b0;
        end
    end

    assign state = state_q;

    // R3: with throttling off, an idle event raises the output next cycle.
    a_r3_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        ivl_zero && (state_q == ST_IDLE) && evt |=> irq_out && (state_q == ST_IDLE));

    // R7: the output holds until a clear is seen.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out && !clr |=> irq_out);

    // R5: a pending event fires when the window ends.
    a_r5_pend_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND) && expire |=> irq_out);

    // R4: a window state always has a live hold-off counter.
    a_r4_state_has_window: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> run);

    // R6: a window that ends with nothing pending returns to idle.
    a_r6_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) && expire && !evt |=> (state_q == ST_IDLE));

endmodule

// File: rtl/irt_throttle.sv
module irt_throttle
    import irt_pkg::*;
#(
    parameter int unsigned TICK_DIV = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             evt_in,
    input  logic             irq_clr,
    output logic             irq_out
);

    localparam int unsigned PAD_W = REG_W - IVL_W;

    logic [IVL_W-1:0] ivl_q;
    logic             ivl_zero;
    logic             tick;
    logic             run;
    logic             expire;
    logic             fire;
    logic             load;
    irt_state_e       state;

    // Interval register; upper bits are not stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ivl_q <= '0;
        end else if (cfg_we) begin
            ivl_q <= cfg_wdata[IVL_W-1:0];
        end
    end

    assign ivl_zero  = (ivl_q == '0);
    assign cfg_rdata = {{PAD_W{1'b0}}, ivl_q};

    irt_prescaler #(
        .DIV (TICK_DIV)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .tick    (tick)
    );

    irt_holdoff #(
        .W (IVL_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (ivl_q),
        .tick     (tick),
        .run      (run),
        .expire   (expire)
    );

    irt_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_in),
        .clr      (irq_clr),
        .ivl_zero (ivl_zero),
        .expire   (expire),
        .run      (run),
        .fire     (fire),
        .load     (load),
        .irq_out  (irq_out),
        .state    (state)
    );

    // R2: written interval is read back on the next cycle.
    a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_rdata[IVL_W-1:0] == $past(cfg_wdata[IVL_W-1:0]));

    // R1/R2: the output rises only through a fire.
    a_r1_rise_needs_fire: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_out && !fire |=> !irq_out);

endmodule

// File: tb/sim_irt_throttle.sv
module sim_irt_throttle;

    localparam int unsigned DIV = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        evt_in = 1'b0;
    logic        irq_clr = 1'b0;
    logic        irq_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    irt_throttle #(.TICK_DIV(DIV)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .evt_in    (evt_in),
        .irq_clr   (irq_clr),
        .irq_out   (irq_out)
    );

    // Timestamp reference model built from the requirements.
    longint cyc = 0;
    longint m_fire_cyc = 0;
    longint m_len = 0;
    bit     m_busy = 0;
    bit     m_pend = 0;
    bit     m_irq = 0;
    int unsigned m_ivl = 0;

    always @(posedge clk) begin
        bit expired;
        bit fire;
        if (!rst_n) begin
            cyc = 0; m_busy = 0; m_pend = 0; m_irq = 0; m_ivl = 0;
        end else begin
            cyc++;
            expired = m_busy && ((cyc - m_fire_cyc) == m_len);
            fire = (!m_busy && evt_in) || (expired && (m_pend || evt_in));
            if (fire) begin
                m_irq = 1;
                m_pend = 0;
                if (m_ivl != 0) begin
                    m_busy = 1;
                    m_fire_cyc = cyc;
                    m_len = longint'(m_ivl) * DIV;
                end else begin
                    m_busy = 0;
                end
            end else begin
                if (expired) begin
                    m_busy = 0;
                    m_pend = 0;
                end else if (m_busy && evt_in) begin
                    m_pend = 1;
                end
                if (irq_clr) m_irq = 0;
            end
            if (cfg_we) m_ivl = cfg_wdata[15:0];
        end
    end

    bit cmp_en = 0;

    function automatic bit exp_rdata_ok(input logic [31:0] rd, input int unsigned iv);
        return rd == {16'h0000, iv[15:0]};
    endfunction

    // Cycle-by-cycle comparison against the model (R4, R5, R7).
    always @(negedge clk) begin
        if (rst_n && cmp_en && !finished) begin
            total++;
            if (irq_out !== m_irq) begin
                bad++;
                $display("FAIL R4 model irq_out at cycle %0d: got %0b exp %0b", cyc, irq_out, m_irq);
            end
            total++;
            if (!exp_rdata_ok(cfg_rdata, m_ivl)) begin
                bad++;
                $display("FAIL R2 model cfg_rdata: got %h exp %h", cfg_rdata, {16'h0, m_ivl[15:0]});
            end
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h exp %0h", req, got, exp);
        end
    endtask

    task automatic write_ivl(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic quiet(input int n);
        evt_in = 1'b0; irq_clr = 1'b1;
        repeat (n) @(negedge clk);
        irq_clr = 1'b0;
    endtask

    // Counts edges until irq_out is high, starting at k0.
    task automatic rise_after(input int k0, output int k);
        k = k0;
        while (!irq_out && k < 5000) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin : main
        int k;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 irq_out after reset", 32'(irq_out), 32'd0);
        check("R1 cfg_rdata after reset", cfg_rdata, 32'd0);
        cmp_en = 1;

        // R2: upper bits dropped
        write_ivl(32'hABCD_0003);
        check("R2 readback", cfg_rdata, 32'h0000_0003);

        // R3: bypass with interval 0
        write_ivl(32'hFFFF_0000);
        check("R2 reserved zero", cfg_rdata, 32'h0);
        evt_in = 1'b1;
        @(negedge clk);
        check("R3 immediate fire", 32'(irq_out), 32'd1);
        irq_clr = 1'b1;
        @(negedge clk);
        check("R7 fire beats clear", 32'(irq_out), 32'd1);
        evt_in = 1'b0;
        @(negedge clk);
        check("R7 clear drops irq", 32'(irq_out), 32'd0);
        irq_clr = 1'b0;
        evt_in = 1'b1;
        @(negedge clk);
        check("R3 no window refire", 32'(irq_out), 32'd1);
        evt_in = 1'b0;
        quiet(4);

        // R4/R5/R9: interval 2, one pending event
        write_ivl(32'd2);
        evt_in = 1'b1;
        @(negedge clk);
        check("R6 idle fire", 32'(irq_out), 32'd1);
        irq_clr = 1'b1;
        @(negedge clk);
        evt_in = 1'b0; irq_clr = 1'b0;
        repeat (20) @(negedge clk);
        evt_in = 1'b1;
        @(negedge clk);
        evt_in = 1'b0;
        rise_after(22, k);
        check("R4 R9 spacing 2*DIV", 32'(k), 32'(2 * DIV));
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        repeat (300) @(negedge clk);
        check("R5 single coalesced fire", 32'(irq_out), 32'd0);

        // R6: idle then immediate fire and new full window
        evt_in = 1'b1;
        @(negedge clk);
        check("R6 immediate after idle", 32'(irq_out), 32'd1);
        evt_in = 1'b1; irq_clr = 1'b1;
        @(negedge clk);
        evt_in = 1'b0; irq_clr = 1'b0;
        rise_after(1, k);
        check("R6 new window length", 32'(k), 32'(2 * DIV));
        repeat (5) @(negedge clk);
        check("R7 held without clear", 32'(irq_out), 32'd1);
        quiet(300);

        // R8: rewrite during a running window
        write_ivl(32'd3);
        evt_in = 1'b1;
        @(negedge clk);
        evt_in = 1'b1; irq_clr = 1'b1; cfg_we = 1'b1; cfg_wdata = 32'd1;
        @(negedge clk);
        evt_in = 1'b0; irq_clr = 1'b0; cfg_we = 1'b0;
        rise_after(1, k);
        check("R8 running window kept", 32'(k), 32'(3 * DIV));
        evt_in = 1'b1; irq_clr = 1'b1;
        @(negedge clk);
        evt_in = 1'b0; irq_clr = 1'b0;
        rise_after(1, k);
        check("R8 new value at next load", 32'(k), 32'(DIV));
        quiet(200);

        // Random phase (R3 R4 R5 R7 R8) checked by the model each cycle.
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            evt_in  = (($urandom % 8) == 0);
            irq_clr = (($urandom % 16) == 0);
            cfg_we  = (($urandom % 400) == 0);
            cfg_wdata = $urandom;
            cfg_wdata[15:0] = 16'($urandom % 5);
        end
        @(negedge clk);
        evt_in = 1'b0; irq_clr = 1'b0; cfg_we = 1'b0;
        repeat (4) @(negedge clk);

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule